// File: doc/BRIEF.md
# HDLC Bit-Serial Receiver with Tagged FIFO and Latched Status

This block is the receive half of an HDLC link channel. Serial line bits arrive one at a time with a valid strobe. The block hunts for the flag byte, delimits frames, removes the zeros the far end inserted after runs of five ones, and packs the surviving bits, least significant bit first, into bytes. Each byte goes into a 32-entry receive FIFO together with a 2-bit packet-end tag. A processor drains the FIFO through a show-ahead read port: the head entry is always visible, and a one-cycle pop strobe advances it.

Line events and FIFO conditions set sticky bits in an 8-bit latched status word. These events are a closing flag, an honoured abort, a go-ahead pattern, an overflow, a high fill level and a last-byte or empty read. A pulse on either the latched-status read strobe or the interrupt-status read strobe clears all of the sticky bits. The interrupt status is the latched word masked by an enable mask, and the interrupt line is the OR of that masked word. A write into a full FIFO switches the receiver off until the next flag is seen. An abort that arrives too early in a frame is treated as line noise and dropped without a trace. Frame check sequence arithmetic is not done here: the only frame validation is on length and byte alignment.

Top module: `hdlc_rx_top`

## Requirements
- R1: A flag is a 0, six 1s and a 0. It opens a frame. A later flag closes that frame and writes its last byte with tag 1 (good) when the frame holds a whole number of bytes, at least two. Every earlier byte is written with tag 0 (none). The tag codes are 0 none, 1 good, 2 abort and 3 invalid.
- R2: Inside a frame, a 0 that follows five consecutive 1s is discarded, and the data bytes come out exactly as they were before the zeros were inserted.
- R3: A frame whose bit count is not a multiple of eight, or which holds fewer than two bytes, ends with an entry tagged 3. Two flags with no bits between them write nothing.
- R4: Seven consecutive 1s inside a frame end it. If at least 26 destuffed bits have been taken in since the opening flag, the last completed byte is written with tag 2 and latched-status bit 2 sets. Otherwise nothing is written and bit 2 stays clear. In both cases the receiver then waits for a flag.
- R5: A 0 followed by seven 1s sets latched-status bit 5 (go-ahead), whether or not a frame is open.
- R6: Every entry written with a non-zero tag sets latched-status bit 4.
- R7: The FIFO holds 32 entries. A write attempted while it is full is dropped and sets latched-status bit 0. It also ends the frame, so no further bytes are written until the next flag has been seen.
- R8: Latched-status bit 1 sets while the reported fill level is above 16.
- R9: Latched-status bit 3 sets while the reported level is 1 and the head entry has a non-zero tag. It also sets when a pop is issued while the FIFO is empty.
- R10: A pulse on lat_rd or on int_rd clears every latched bit. A set condition in the same cycle wins over the clear.
- R11: int_stat is the latched word ANDed with irq_mask, and irq is high exactly when int_stat is non-zero.
- R12: fifo_level, and the status derived from it, follow a write or a pop one cycle after the clock edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit | input | 1 | Serial line bit |
| rx_bit_vld | input | 1 | rx_bit is valid this cycle |
| rd_pop | input | 1 | Pop the head FIFO entry |
| rd_data | output | 8 | Head entry data byte |
| rd_tag | output | 2 | Head entry packet-end tag |
| fifo_level | output | 6 | Reported fill level (lags by one cycle) |
| lat_rd | input | 1 | Latched-status read strobe, clears latches |
| int_rd | input | 1 | Interrupt-status read strobe, clears latches |
| irq_mask | input | 8 | Interrupt enable per latched bit |
| lat_stat | output | 8 | Latched status word |
| int_stat | output | 8 | Masked latched status |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the framing boundaries. It uses data bytes that force zero insertion, a frame cut three bits past a byte boundary, a one-byte frame, and back-to-back flags. A design that lost the flag's leading bits into the data, or that failed to strip an inserted zero, would corrupt or shift bytes. A wrong length rule would tag the short frames as good. It places aborts on both sides of the 26-bit threshold, using 22 bits and 30 bits, so a threshold that is off, or an early abort that still writes, shows up as a wrong tag or an extra entry. It overfills the FIFO with a 34-byte frame and then checks that exactly 32 entries remain and that the next flagged frame is received intact, which catches a receiver that keeps writing or never recovers. It also checks the one-cycle lag of the level after a pop, the read-from-empty latch, and both clear paths.

// File: rtl/hdlc_rx_pkg.sv
// Shared types for the HDLC receiver: entry tag encoding, FIFO entry layout,
// latched-status bit positions and the flag delay length.
package hdlc_rx_pkg;

    typedef enum logic [1:0] {
        EOP_NONE  = 2'd0,
        EOP_GOOD  = 2'd1,
        EOP_ABORT = 2'd2,
        EOP_BAD   = 2'd3
    } eop_tag_t;

    typedef struct packed {
        eop_tag_t   tag;
        logic [7:0] data;
    } rx_entry_t;

    localparam int ST_W       = 8;
    localparam int ST_OVF     = 0;
    localparam int ST_HIGH    = 1;
    localparam int ST_ABORT   = 2;
    localparam int ST_EOPRD   = 3;
    localparam int ST_EOPDET  = 4;
    localparam int ST_GOAHEAD = 5;

    // Bits of a closing flag that enter the data path before it is recognised.
    localparam int FLAG_LAG = 7;

endpackage

// File: rtl/hdlc_rx_deframer.sv
// Bit-level HDLC receive engine.
// It tracks runs of ones to find flags, aborts and go-ahead patterns, and deletes
// inserted zeros. Data bits pass through a FLAG_LAG-bit delay line, so the flag
// prefix is discarded before it can reach a byte. One completed byte is held back
// so that it can be tagged when the frame ends.
// Assumes: bits arrive LSB first. ovf_kill is a one-cycle pulse from the FIFO side.
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter int ABORT_MIN_BITS = 26,
    parameter int MIN_BYTES      = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bit_in,
    input  logic      bit_vld,
    input  logic      ovf_kill,
    output logic      wr_req,
    output rx_entry_t wr_entry,
    output logic      goahead_evt,
    output logic      abort_evt
);

    localparam int FBW = $clog2(ABORT_MIN_BITS + 1);
    localparam int BCW = $clog2(MIN_BYTES + 1);
    localparam int DLW = $clog2(FLAG_LAG + 1);

    logic [2:0]          ones;
    logic                zero_seen;
    logic                in_frame;
    logic [FLAG_LAG-1:0] dly;
    logic [DLW-1:0]      dly_n;
    logic [7:0]          asm_q;
    logic [2:0]          bitpos;
    logic [BCW-1:0]      byte_cnt;
    logic [7:0]          held;
    logic                held_v;
    logic [FBW-1:0]      frm_bits;

    logic      seen_flag, seen_seven, seen_stuff, push, exits;
    logic      idle_close, frame_bad, frame_long;
    logic [7:0] new_byte;

    // Decode what the current bit means for the framing state.
    always_comb begin
        seen_flag  = bit_vld && !bit_in && (ones == 3'd6);
        seen_seven = bit_vld &&  bit_in && (ones == 3'd6);
        seen_stuff = bit_vld && in_frame && !bit_in && (ones == 3'd5);
        push       = bit_vld && in_frame && !seen_flag && !seen_seven && !seen_stuff;
        exits      = push && (dly_n == DLW'(FLAG_LAG));
        new_byte   = {dly[0], asm_q[7:1]};
        idle_close = (byte_cnt == '0) && (bitpos == 3'd0);
        frame_bad  = (bitpos != 3'd0) || (byte_cnt < BCW'(MIN_BYTES));
        frame_long = (frm_bits >= FBW'(ABORT_MIN_BITS));
    end

    // Framing state, bit delay line, byte assembly and FIFO write generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones        <= 3'd0;
            zero_seen   <= 1'b0;
            in_frame    <= 1'b0;
            dly         <= '0;
            dly_n       <= '0;
            asm_q       <= '0;
            bitpos      <= 3'd0;
            byte_cnt    <= '0;
            held        <= '0;
            held_v      <= 1'b0;
            frm_bits    <= '0;
            wr_req      <= 1'b0;
            wr_entry    <= '0;
            goahead_evt <= 1'b0;
            abort_evt   <= 1'b0;
        end else begin
            wr_req      <= 1'b0;
            goahead_evt <= 1'b0;
            abort_evt   <= 1'b0;
            if (bit_vld) begin
                ones <= bit_in ? ((ones == 3'd7) ? 3'd7 : ones + 3'd1) : 3'd0;
                if (!bit_in) zero_seen <= 1'b1;
                if (seen_seven && zero_seen) goahead_evt <= 1'b1;
            end
            if (seen_flag) begin
                if (in_frame && !idle_close) begin
                    wr_req        <= 1'b1;
                    wr_entry.data <= held_v ? held : 8'h00;
                    wr_entry.tag  <= frame_bad ? EOP_BAD : EOP_GOOD;
                end
                in_frame <= 1'b1;
                dly_n    <= '0;
                bitpos   <= 3'd0;
                byte_cnt <= '0;
                held_v   <= 1'b0;
                frm_bits <= '0;
            end else if (seen_seven) begin
                if (in_frame && frame_long) begin
                    wr_req        <= 1'b1;
                    wr_entry.data <= held;
                    wr_entry.tag  <= EOP_ABORT;
                    abort_evt     <= 1'b1;
                end
                in_frame <= 1'b0;
            end else if (push) begin
                dly <= {bit_in, dly[FLAG_LAG-1:1]};
                if (dly_n != DLW'(FLAG_LAG)) dly_n <= dly_n + 1'b1;
                if (!frame_long) frm_bits <= frm_bits + 1'b1;
                if (exits) begin
                    asm_q  <= new_byte;
                    bitpos <= bitpos + 3'd1;
                    if (bitpos == 3'd7) begin
                        held   <= new_byte;
                        held_v <= 1'b1;
                        if (byte_cnt < BCW'(MIN_BYTES)) byte_cnt <= byte_cnt + 1'b1;
                        if (held_v) begin
                            wr_req        <= 1'b1;
                            wr_entry.data <= held;
                            wr_entry.tag  <= EOP_NONE;
                        end
                    end
                end
            end
            if (ovf_kill) in_frame <= 1'b0;
        end
    end

endmodule

// File: rtl/hdlc_rx_fifo.sv
// Tagged receive FIFO with a show-ahead head.
// Pointers move on the edge that performs a push or a pop. The reported level and
// the head tag snapshot are registered from the pointers, so they lag by one cycle.
// Assumes: the writer checks full itself, and pushes while full are dropped here.
module hdlc_rx_fifo
    import hdlc_rx_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_req,
    input  rx_entry_t              wr_entry,
    input  logic                   rd_req,
    output rx_entry_t              head,
    output eop_tag_t               head_tag_q,
    output logic [$clog2(DEPTH):0] level_q,
    output logic                   full,
    output logic                   empty
);

    localparam int AW = $clog2(DEPTH);

    rx_entry_t   mem [DEPTH];
    logic [AW:0] wptr, rptr;
    logic [AW:0] used;
    logic        do_push, do_pop;

    // Occupancy from the live pointers, for overflow and underflow protection.
    always_comb begin
        used    = wptr - rptr;
        full    = (used == (AW+1)'(DEPTH));
        empty   = (used == '0);
        do_push = wr_req && !full;
        do_pop  = rd_req && !empty;
        head    = mem[rptr[AW-1:0]];
    end

    // Storage write port.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr[AW-1:0]] <= wr_entry;
    end

    // Pointer update and the lagged status snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr       <= '0;
            rptr       <= '0;
            level_q    <= '0;
            head_tag_q <= EOP_NONE;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            level_q    <= used;
            head_tag_q <= empty ? EOP_NONE : head.tag;
        end
    end

endmodule

// File: rtl/hdlc_rx_status.sv
// Latched status word and interrupt masking.
// Each bit is sticky. A pulse on either read strobe clears the whole word, and a
// set in the same cycle wins over the clear.
// Assumes: event inputs are single-cycle pulses, and level inputs are the lagged FIFO view.
module hdlc_rx_status
    import hdlc_rx_pkg::*;
#(
    parameter int DEPTH     = 32,
    parameter int HIGH_MARK = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ovf_evt,
    input  logic                   abort_evt,
    input  logic                   eopdet_evt,
    input  logic                   goahead_evt,
    input  logic                   rd_empty_evt,
    input  logic [$clog2(DEPTH):0] level_q,
    input  eop_tag_t               head_tag_q,
    input  logic                   lat_rd,
    input  logic                   int_rd,
    input  logic [ST_W-1:0]        irq_mask,
    output logic [ST_W-1:0]        lat_q,
    output logic [ST_W-1:0]        int_stat,
    output logic                   irq
);

    localparam int LW = $clog2(DEPTH) + 1;

    logic [ST_W-1:0] set_v;

    // Gather the set conditions for this cycle.
    always_comb begin
        set_v              = '0;
        set_v[ST_OVF]      = ovf_evt;
        set_v[ST_HIGH]     = (level_q > LW'(HIGH_MARK));
        set_v[ST_ABORT]    = abort_evt;
        set_v[ST_EOPRD]    = rd_empty_evt ||
                             ((level_q == LW'(1)) && (head_tag_q != EOP_NONE));
        set_v[ST_EOPDET]   = eopdet_evt;
        set_v[ST_GOAHEAD]  = goahead_evt;
    end

    // Sticky latches with clear on either register read.
    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= ((lat_rd || int_rd) ? '0 : lat_q) | set_v;
    end

    // Masked view and interrupt line.
    always_comb begin
        int_stat = lat_q & irq_mask;
        irq      = |int_stat;
    end

endmodule

// File: rtl/hdlc_rx_top.sv
// HDLC receiver top: deframer feeding a tagged FIFO, with latched status.
// A write into a full FIFO is dropped, and the deframer is sent back to flag hunt.
// Assumes: a single clock domain, with the serial bit already sampled into it.
module hdlc_rx_top
    import hdlc_rx_pkg::*;
#(
    parameter int DEPTH          = 32,
    parameter int HIGH_MARK      = 16,
    parameter int ABORT_MIN_BITS = 26,
    parameter int MIN_BYTES      = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_bit,
    input  logic                   rx_bit_vld,
    input  logic                   rd_pop,
    output logic [7:0]             rd_data,
    output logic [1:0]             rd_tag,
    output logic [$clog2(DEPTH):0] fifo_level,
    input  logic                   lat_rd,
    input  logic                   int_rd,
    input  logic [ST_W-1:0]        irq_mask,
    output logic [ST_W-1:0]        lat_stat,
    output logic [ST_W-1:0]        int_stat,
    output logic                   irq
);

    logic      df_wr, df_goahead, df_abort;
    rx_entry_t df_entry;
    rx_entry_t ff_head;
    eop_tag_t  ff_tag_q;
    logic      ff_full, ff_empty;
    logic      ovf_evt, eopdet_evt, rd_empty_evt;

    // Cross-unit events: a dropped write, an accepted packet end, a pop while empty.
    always_comb begin
        ovf_evt      = df_wr && ff_full;
        eopdet_evt   = df_wr && !ff_full && (df_entry.tag != EOP_NONE);
        rd_empty_evt = rd_pop && ff_empty;
        rd_data      = ff_head.data;
        rd_tag       = ff_head.tag;
    end

    hdlc_rx_deframer #(
        .ABORT_MIN_BITS (ABORT_MIN_BITS),
        .MIN_BYTES      (MIN_BYTES)
    ) deframer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_in      (rx_bit),
        .bit_vld     (rx_bit_vld),
        .ovf_kill    (ovf_evt),
        .wr_req      (df_wr),
        .wr_entry    (df_entry),
        .goahead_evt (df_goahead),
        .abort_evt   (df_abort)
    );

    hdlc_rx_fifo #(
        .DEPTH (DEPTH)
    ) fifo_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (df_wr),
        .wr_entry   (df_entry),
        .rd_req     (rd_pop),
        .head       (ff_head),
        .head_tag_q (ff_tag_q),
        .level_q    (fifo_level),
        .full       (ff_full),
        .empty      (ff_empty)
    );

    hdlc_rx_status #(
        .DEPTH     (DEPTH),
        .HIGH_MARK (HIGH_MARK)
    ) status_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ovf_evt      (ovf_evt),
        .abort_evt    (df_abort),
        .eopdet_evt   (eopdet_evt),
        .goahead_evt  (df_goahead),
        .rd_empty_evt (rd_empty_evt),
        .level_q      (fifo_level),
        .head_tag_q   (ff_tag_q),
        .lat_rd       (lat_rd),
        .int_rd       (int_rd),
        .irq_mask     (irq_mask),
        .lat_q        (lat_stat),
        .int_stat     (int_stat),
        .irq          (irq)
    );

endmodule

// File: rtl/hdlc_rx_chk.sv
// Property checker for hdlc_rx_top, attached with bind.
// It watches the write/full interaction, the level bounds, the clear rule and masking.
module hdlc_rx_chk #(
    parameter int DEPTH     = 32,
    parameter int HIGH_MARK = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_req,
    input logic                   fifo_full,
    input logic [$clog2(DEPTH):0] fifo_level,
    input logic                   lat_rd,
    input logic                   int_rd,
    input logic [7:0]             lat_stat,
    input logic [7:0]             irq_mask,
    input logic                   irq
);

    localparam int LW = $clog2(DEPTH) + 1;

    assert_ovf_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && fifo_full) |=> lat_stat[0]);

    assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LW'(DEPTH));

    assert_high_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level > LW'(HIGH_MARK)) |=> lat_stat[1]);

    assert_clear_only_by_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(lat_stat) & ~lat_stat)) |-> $past(lat_rd || int_rd));

    assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == 8'h00) |-> !irq);

endmodule

bind hdlc_rx_top hdlc_rx_chk #(
    .DEPTH     (DEPTH),
    .HIGH_MARK (HIGH_MARK)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_req     (df_wr),
    .fifo_full  (ff_full),
    .fifo_level (fifo_level),
    .lat_rd     (lat_rd),
    .int_rd     (int_rd),
    .lat_stat   (lat_stat),
    .irq_mask   (irq_mask),
    .irq        (irq)
);

// File: tb/hdlc_rx_top_tb_top.sv
`timescale 1ns/1ps
module hdlc_rx_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bit = 1'b0;
    logic       rx_bit_vld = 1'b0;
    logic       mon_pop = 1'b0;
    logic       tb_pop = 1'b0;
    logic       rd_pop;
    logic [7:0] rd_data;
    logic [1:0] rd_tag;
    logic [5:0] fifo_level;
    logic       lat_rd = 1'b0;
    logic       int_rd = 1'b0;
    logic [7:0] irq_mask = 8'h00;
    logic [7:0] lat_stat;
    logic [7:0] int_stat;
    logic       irq;

    int  checks = 0;
    int  errors = 0;
    int  tb_ones = 0;
    bit  mon_en = 1'b0;
    bit  done = 1'b0;
    int  exp_q[$];

    assign rd_pop = mon_pop | tb_pop;

    always #2.5 clk = ~clk;

    hdlc_rx_top dut_i (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld),
        .rd_pop(rd_pop), .rd_data(rd_data), .rd_tag(rd_tag), .fifo_level(fifo_level),
        .lat_rd(lat_rd), .int_rd(int_rd), .irq_mask(irq_mask),
        .lat_stat(lat_stat), .int_stat(int_stat), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic raw_bit(input bit b);
        @(negedge clk);
        rx_bit     = b;
        rx_bit_vld = 1'b1;
    endtask

    task automatic line_idle();
        @(negedge clk);
        rx_bit_vld = 1'b0;
    endtask

    task automatic tx_flag();
        raw_bit(0);
        for (int i = 0; i < 6; i++) raw_bit(1);
        raw_bit(0);
        tb_ones = 0;
    endtask

    // Sends a data bit and inserts a zero after five ones.
    task automatic tx_dbit(input bit b);
        raw_bit(b);
        if (b) begin
            tb_ones++;
            if (tb_ones == 5) begin
                raw_bit(0);
                tb_ones = 0;
            end
        end else tb_ones = 0;
    endtask

    task automatic tx_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) tx_dbit(v[i]);
    endtask

    task automatic tx_seven_ones();
        for (int i = 0; i < 7; i++) raw_bit(1);
        tb_ones = 0;
    endtask

    task automatic expect_entry(input int tag, input int data);
        exp_q.push_back((tag << 8) | data);
    endtask

    task automatic clear_lat(input bit use_int);
        @(negedge clk);
        if (use_int) int_rd = 1'b1; else lat_rd = 1'b1;
        @(negedge clk);
        int_rd = 1'b0;
        lat_rd = 1'b0;
        tick(2);
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 3000; i++) begin
            if (exp_q.size() == 0 && fifo_level == 0) break;
            @(negedge clk);
        end
        tick(4);
        chk(exp_q.size() == 0, "R1", "scoreboard drained", exp_q.size(), 0);
    endtask

    // Scoreboard monitor: pops each head entry and compares it with the queue.
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && fifo_level != 0) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1", "unexpected entry", {22'd0, rd_tag, rd_data}, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk({22'd0, rd_tag, rd_data} == e, "R1", "fifo entry {tag,data}",
                        {22'd0, rd_tag, rd_data}, e);
                end
                mon_pop = 1'b1;
                @(negedge clk);
                mon_pop = 1'b0;
                @(negedge clk);
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            chk(1'b0, "R1", "watchdog expired", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(2);
        // Reset state.
        chk(lat_stat == 8'h00, "R10", "reset latches", lat_stat, 0);
        chk(fifo_level == 0, "R12", "reset level", fifo_level, 0);
        chk(irq == 1'b0, "R11", "reset irq", irq, 0);

        // R1 good frame, R6 packet-end latch, R9 last-byte latch.
        mon_en = 1'b1;
        expect_entry(0, 8'h11); expect_entry(0, 8'h22);
        expect_entry(0, 8'h33); expect_entry(1, 8'h44);
        tx_flag();
        tx_byte(8'h11); tx_byte(8'h22); tx_byte(8'h33); tx_byte(8'h44);
        tx_flag();
        line_idle();
        wait_drain();
        chk(lat_stat[4] == 1'b1, "R6", "packet-end latch after good frame", lat_stat[4], 1);
        chk(lat_stat[3] == 1'b1, "R9", "last-byte latch", lat_stat[3], 1);
        clear_lat(1'b0);
        chk(lat_stat == 8'h00, "R10", "clear via lat_rd", lat_stat, 0);

        // R2 zero deletion.
        expect_entry(0, 8'hFF); expect_entry(0, 8'h7E);
        expect_entry(0, 8'h3F); expect_entry(1, 8'hF8);
        tx_flag();
        tx_byte(8'hFF); tx_byte(8'h7E); tx_byte(8'h3F); tx_byte(8'hF8);
        tx_flag();
        line_idle();
        wait_drain();
        chk(lat_stat != 8'h00, "R10", "latches set before int_rd", lat_stat, 8'h18);
        clear_lat(1'b1);
        chk(lat_stat == 8'h00, "R10", "clear via int_rd", lat_stat, 0);

        // R3 back-to-back flags write nothing.
        tx_flag(); tx_flag(); tx_flag();
        line_idle();
        tick(10);
        chk(lat_stat[4] == 1'b0, "R3", "no entry between flags", lat_stat[4], 0);
        chk(fifo_level == 0, "R3", "level after empty frames", fifo_level, 0);

        // R3 one-byte frame.
        expect_entry(3, 8'h5A);
        tx_flag(); tx_byte(8'h5A); tx_flag();
        line_idle();
        wait_drain();

        // R3 misaligned frame.
        expect_entry(0, 8'hA5); expect_entry(3, 8'h3C);
        tx_flag(); tx_byte(8'hA5); tx_byte(8'h3C);
        tx_dbit(1); tx_dbit(0); tx_dbit(1);
        tx_flag();
        line_idle();
        wait_drain();
        clear_lat(1'b0);

        // R4 early abort: 22 bits, ignored.
        tx_flag(); tx_byte(8'h12); tx_byte(8'h34); tx_seven_ones();
        line_idle();
        tick(10);
        chk(lat_stat[2] == 1'b0, "R4", "early abort ignored", lat_stat[2], 0);
        chk(fifo_level == 0, "R4", "early abort writes nothing", fifo_level, 0);

        // R4 honoured abort: 30 bits.
        expect_entry(0, 8'h12); expect_entry(2, 8'h34);
        tx_flag(); tx_byte(8'h12); tx_byte(8'h34); tx_byte(8'h56); tx_seven_ones();
        line_idle();
        wait_drain();
        chk(lat_stat[2] == 1'b1, "R4", "abort latch", lat_stat[2], 1);
        chk(lat_stat[4] == 1'b1, "R6", "packet-end latch on abort", lat_stat[4], 1);
        clear_lat(1'b0);

        // R5 go-ahead.
        chk(lat_stat[5] == 1'b0, "R5", "go-ahead clear", lat_stat[5], 0);
        raw_bit(0); tx_seven_ones();
        line_idle();
        tick(4);
        chk(lat_stat[5] == 1'b1, "R5", "go-ahead latch", lat_stat[5], 1);

        // R11 masking.
        irq_mask = 8'h00; tick(2);
        chk(irq == 1'b0, "R11", "irq masked", irq, 0);
        irq_mask = 8'h20; tick(2);
        chk(irq == 1'b1, "R11", "irq on go-ahead", irq, 1);
        chk(int_stat == 8'h20, "R11", "int_stat", int_stat, 8'h20);
        irq_mask = 8'h01; tick(2);
        chk(irq == 1'b0, "R11", "irq other bit only", irq, 0);
        irq_mask = 8'h00;
        clear_lat(1'b1);

        // R9 pop while empty.
        mon_en = 1'b0;
        @(negedge clk); tb_pop = 1'b1;
        @(negedge clk); tb_pop = 1'b0;
        tick(2);
        chk(lat_stat[3] == 1'b1, "R9", "empty read latch", lat_stat[3], 1);
        clear_lat(1'b0);

        // R7 overflow, R8 high level.
        tx_flag();
        for (int i = 0; i < 34; i++) tx_byte(8'(i));
        tx_flag();
        line_idle();
        tick(10);
        chk(fifo_level == 32, "R7", "level at full", fifo_level, 32);
        chk(lat_stat[0] == 1'b1, "R7", "overflow latch", lat_stat[0], 1);
        chk(lat_stat[1] == 1'b1, "R8", "high latch", lat_stat[1], 1);
        for (int i = 0; i < 32; i++) expect_entry(0, i);
        mon_en = 1'b1;
        wait_drain();
        clear_lat(1'b0);
        chk(lat_stat[1] == 1'b0, "R8", "high latch clear after drain", lat_stat[1], 0);
        expect_entry(0, 8'h77); expect_entry(1, 8'h88);
        tx_flag(); tx_byte(8'h77); tx_byte(8'h88); tx_flag();
        line_idle();
        wait_drain();
        clear_lat(1'b0);

        // R12 level lag after a pop.
        mon_en = 1'b0;
        tx_flag(); tx_byte(8'h01); tx_byte(8'h02); tx_flag();
        line_idle();
        tick(10);
        chk(fifo_level == 2, "R12", "level before pop", fifo_level, 2);
        @(negedge clk); tb_pop = 1'b1;
        @(negedge clk); tb_pop = 1'b0;
        chk(fifo_level == 2, "R12", "level one cycle after pop edge", fifo_level, 2);
        chk(rd_data == 8'h02 && rd_tag == 2'd1, "R12", "head after pop",
            {rd_tag, rd_data}, 10'h102);
        @(negedge clk);
        chk(fifo_level == 1, "R12", "level updated", fifo_level, 1);
        @(negedge clk); tb_pop = 1'b1;
        @(negedge clk); tb_pop = 1'b0;
        tick(4);
        chk(fifo_level == 0, "R12", "level after last pop", fifo_level, 0);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule